// File: doc/BRIEF.md
# Asynchronous SRAM Access Sequencer

This block turns single-beat requests from an on-chip port into correctly timed pin sequences for an external 8K x 8 asynchronous static RAM. A request is accepted on a valid/ready handshake and carries a read/write flag, a 13-bit address and a byte of write data. Reads return a byte together with a one-cycle completion pulse. Writes give the same pulse when the write cycle closes.

The memory has two chip selects of opposite polarity, plus active-low write and output enables. It shares one 8-bit data bus with the controller, and the controller drives that bus through a separate output-enable. Every interval on the pins is a whole number of clock cycles. Each count is derived at elaboration from a nanosecond figure and the clock period, rounded up. With the default 10 ns clock this gives a 5-cycle write strobe, a 1-cycle write recovery, a 6-cycle read window and a 2-cycle bus release after a read.

Requests arriving while an access is in flight are not taken. The request fields are captured at acceptance, so changes to them later have no effect on the access already running.

Top module: `sram_seq_ctrl`

## Requirements
- R1: During and immediately after reset: req_ready=1, rsp_done=0, mem_ce_n=1, mem_ce2=0, mem_we_n=1, mem_oe_n=1 and mem_dq_oe=0.
- R2: The memory is selected (mem_ce_n=0 together with mem_ce2=1) only while an access is in progress. Whenever req_ready is 1, mem_ce_n=1 and mem_ce2=0.
- R3: mem_we_n is low only while the memory is selected and mem_oe_n is high. The byte on mem_dq_out when mem_we_n rises is the request's write data, and it is stored at the request's address.
- R4: mem_addr equals the accepted request address from the first cycle of the access, and it does not change while mem_we_n is low.
- R5: A write holds mem_we_n low for exactly WP cycles (5 at default), where WP = ceil(max(45 ns, 25 ns) / period). The recovery that follows lasts max(1, ceil(55 ns / period) - WP) cycles. At default, rsp_done is 1 and req_ready returns in the 7th cycle after the accepting edge.
- R6: mem_dq_oe is 1 only while mem_oe_n is 1. It rises no earlier than ceil(20 ns / period) cycles after mem_oe_n was last low, and it falls one cycle after mem_we_n rises. The controller and the memory never drive the bus in the same cycle.
- R7: A read holds mem_oe_n low with mem_we_n high for ceil(55 ns / period) cycles (6 at default). rsp_rdata takes the bus value of the last of those cycles. rsp_done is 1 in the 7th cycle after the accepting edge.
- R8: After a read, the memory is deselected with mem_oe_n high for ceil(20 ns / period) cycles (2 at default) before req_ready returns, in the 9th cycle after the accepting edge.
- R9: rsp_done is a single-cycle pulse and req_ready is 0 from the cycle after acceptance until the access ends. Changes to req_addr or req_wdata after acceptance do not alter the access in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 13 | Byte address |
| req_wdata | input | 8 | Write byte |
| req_ready | output | 1 | Controller idle and able to accept |
| rsp_rdata | output | 8 | Last read byte |
| rsp_done | output | 1 | One-cycle completion pulse |
| mem_addr | output | 13 | Memory address pins |
| mem_ce_n | output | 1 | Active-low chip select |
| mem_ce2 | output | 1 | Active-high chip select |
| mem_we_n | output | 1 | Active-low write strobe |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_dq_out | output | 8 | Byte driven onto the shared bus |
| mem_dq_oe | output | 1 | Enable of the controller's bus drivers |
| mem_dq_in | input | 8 | Byte seen on the shared bus |

## Verification
Counted from the edge that accepts a request, the completion pulse of both reads and writes falls in the 7th cycle. A write returns ready in that same 7th cycle, and a read returns it in the 9th. The bench samples every pin at the falling edge after each rising edge and numbers those samples from the accepting edge. Its latencies, strobe lengths and output-enable lengths therefore come out as plain cycle counts, which it compares against the figures above. A bus model that keeps driving for two cycles after output enable rises lets any early driver enable show up as a conflict in the very cycle it happens.

// File: rtl/sram_seq_pkg.sv
package sram_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_WSTRB = 3'd1,
    ST_WHOLD = 3'd2,
    ST_READ  = 3'd3,
    ST_RTURN = 3'd4
  } seq_state_t;

  // whole cycles needed to cover an interval, rounded up
  function automatic int ns_to_cyc(input int ns, input int period_ns);
    return (ns + period_ns - 1) / period_ns;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  function automatic int bits_for(input int v);
    return (v < 2) ? 1 : $clog2(v + 1);
  endfunction

endpackage

// File: rtl/sram_seq_timer.sv
module sram_seq_timer #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)            cnt <= '0;
    else if (load)         cnt <= load_val;
    else if (cnt != '0)    cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
  import sram_seq_pkg::*;
#(
  parameter int WP_CYC   = 5,
  parameter int HOLD_CYC = 1,
  parameter int RC_CYC   = 6,
  parameter int HZ_CYC   = 2,
  parameter int CNT_W    = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic             expired,
  output logic             accept,
  output logic             capture,
  output logic             done_set,
  output logic             load,
  output logic [CNT_W-1:0] load_val,
  output logic             idle,
  output logic             sel,
  output logic             we_act,
  output logic             oe_act,
  output logic             drv
);
  localparam logic [CNT_W-1:0] WP_LD   = CNT_W'(WP_CYC - 1);
  localparam logic [CNT_W-1:0] HOLD_LD = CNT_W'(HOLD_CYC - 1);
  localparam logic [CNT_W-1:0] RC_LD   = CNT_W'(RC_CYC - 1);
  localparam logic [CNT_W-1:0] HZ_LD   = CNT_W'(HZ_CYC - 1);

  seq_state_t state, nxt;

  always_comb begin
    nxt      = state;
    accept   = 1'b0;
    capture  = 1'b0;
    done_set = 1'b0;
    load     = 1'b0;
    load_val = '0;
    unique case (state)
      ST_IDLE: if (req_valid) begin
        accept   = 1'b1;
        load     = 1'b1;
        load_val = req_write ? WP_LD : RC_LD;
        nxt      = req_write ? ST_WSTRB : ST_READ;
      end
      ST_WSTRB: if (expired) begin
        load     = 1'b1;
        load_val = HOLD_LD;
        nxt      = ST_WHOLD;
      end
      ST_WHOLD: if (expired) begin
        done_set = 1'b1;
        nxt      = ST_IDLE;
      end
      ST_READ: if (expired) begin
        capture  = 1'b1;
        done_set = 1'b1;
        load     = 1'b1;
        load_val = HZ_LD;
        nxt      = ST_RTURN;
      end
      ST_RTURN: if (expired) nxt = ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nxt;
  end

  // pin intent decoded from the registered state only
  assign idle   = (state == ST_IDLE);
  assign sel    = (state == ST_WSTRB) || (state == ST_WHOLD) || (state == ST_READ);
  assign we_act = (state == ST_WSTRB);
  assign oe_act = (state == ST_READ);
  assign drv    = (state == ST_WSTRB) || (state == ST_WHOLD);
endmodule

// File: rtl/sram_seq_dpath.sv
module sram_seq_dpath #(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              capture,
  input  logic              done_set,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] bus_in,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] wdata_q,
  output logic [DATA_W-1:0] rdata_q,
  output logic              done_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
      done_q  <= 1'b0;
    end else begin
      if (accept) begin
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
      end
      if (capture) rdata_q <= bus_in;
      done_q <= done_set;
    end
  end
endmodule

// File: rtl/sram_seq_ctrl.sv
module sram_seq_ctrl
  import sram_seq_pkg::*;
#(
  parameter int ADDR_W        = 13,
  parameter int DATA_W        = 8,
  parameter int CLK_PERIOD_NS = 10,
  parameter int STROBE_NS     = 45,
  parameter int WCYCLE_NS     = 55,
  parameter int DSETUP_NS     = 25,
  parameter int RCYCLE_NS     = 55,
  parameter int RELEASE_NS    = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ready,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_done,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_ce2,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);
  // drivers are on for the whole strobe, so it must also cover data setup
  localparam int WP_CYC   = max2(ns_to_cyc(STROBE_NS, CLK_PERIOD_NS),
                                 ns_to_cyc(DSETUP_NS, CLK_PERIOD_NS));
  localparam int HOLD_CYC = max2(1, ns_to_cyc(WCYCLE_NS, CLK_PERIOD_NS) - WP_CYC);
  localparam int RC_CYC   = max2(1, ns_to_cyc(RCYCLE_NS, CLK_PERIOD_NS));
  localparam int HZ_CYC   = max2(1, ns_to_cyc(RELEASE_NS, CLK_PERIOD_NS));
  localparam int MAX_CYC  = max2(max2(WP_CYC, HOLD_CYC), max2(RC_CYC, HZ_CYC));
  localparam int CNT_W    = bits_for(MAX_CYC);

  // named internal events, also used by the bound checker
  logic             ev_accept, ev_capture, ev_done_set, ev_load, ev_expired;
  logic [CNT_W-1:0] ev_load_val;
  logic             st_idle, pin_sel, pin_we, pin_oe, pin_drv;

  sram_seq_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (ev_load),
    .load_val (ev_load_val),
    .expired  (ev_expired)
  );

  sram_seq_fsm #(
    .WP_CYC(WP_CYC), .HOLD_CYC(HOLD_CYC), .RC_CYC(RC_CYC),
    .HZ_CYC(HZ_CYC), .CNT_W(CNT_W)
  ) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .req_write(req_write),
    .expired  (ev_expired),
    .accept   (ev_accept),
    .capture  (ev_capture),
    .done_set (ev_done_set),
    .load     (ev_load),
    .load_val (ev_load_val),
    .idle     (st_idle),
    .sel      (pin_sel),
    .we_act   (pin_we),
    .oe_act   (pin_oe),
    .drv      (pin_drv)
  );

  sram_seq_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dpath (
    .clk      (clk),
    .rst_n    (rst_n),
    .accept   (ev_accept),
    .capture  (ev_capture),
    .done_set (ev_done_set),
    .req_addr (req_addr),
    .req_wdata(req_wdata),
    .bus_in   (mem_dq_in),
    .addr_q   (mem_addr),
    .wdata_q  (mem_dq_out),
    .rdata_q  (rsp_rdata),
    .done_q   (rsp_done)
  );

  assign req_ready = st_idle;
  assign mem_ce_n  = ~pin_sel;
  assign mem_ce2   = pin_sel;
  assign mem_we_n  = ~pin_we;
  assign mem_oe_n  = ~pin_oe;
  assign mem_dq_oe = pin_drv;
endmodule

// File: rtl/sram_seq_ctrl_chk.sv
module sram_seq_ctrl_chk #(
  parameter int ADDR_W = 13,
  parameter int WP_CYC = 5,
  parameter int HZ_CYC = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              rsp_done,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_ce_n,
  input logic              mem_ce2,
  input logic              mem_we_n,
  input logic              mem_oe_n,
  input logic              mem_dq_oe,
  input logic              ev_accept,
  input logic              ev_capture
);
  logic       selected;
  logic [7:0] we_low_cnt;
  logic [7:0] oe_high_cnt;

  assign selected = !mem_ce_n && mem_ce2;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      we_low_cnt  <= '0;
      oe_high_cnt <= 8'hff;
    end else begin
      we_low_cnt  <= !mem_we_n ? we_low_cnt + 8'd1 : 8'd0;
      if (!mem_oe_n)                oe_high_cnt <= '0;
      else if (oe_high_cnt != 8'hff) oe_high_cnt <= oe_high_cnt + 8'd1;
    end
  end

  p_idle_deselected_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_ce_n && !mem_ce2));

  p_we_while_selected_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (selected && mem_oe_n));

  p_addr_steady_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_we_n && $past(!mem_we_n)) |-> $stable(mem_addr));

  p_strobe_width_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (we_low_cnt == 8'(WP_CYC)));

  p_no_fight_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> (mem_oe_n && oe_high_cnt >= 8'(HZ_CYC)));

  p_read_pins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> (mem_we_n && selected));

  p_capture_reports_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_capture |=> rsp_done);

  p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);

  p_busy_after_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ev_accept |=> !req_ready);
endmodule

bind sram_seq_ctrl sram_seq_ctrl_chk #(
  .ADDR_W(ADDR_W), .WP_CYC(WP_CYC), .HZ_CYC(HZ_CYC)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_ready (req_ready),
  .rsp_done  (rsp_done),
  .mem_addr  (mem_addr),
  .mem_ce_n  (mem_ce_n),
  .mem_ce2   (mem_ce2),
  .mem_we_n  (mem_we_n),
  .mem_oe_n  (mem_oe_n),
  .mem_dq_oe (mem_dq_oe),
  .ev_accept (ev_accept),
  .ev_capture(ev_capture)
);

// File: tb/sram_seq_ctrl_test.sv
module sram_seq_ctrl_test;
  localparam int PERIOD = 10;
  // expected figures restated from the requirements for a 10 ns clock
  localparam int EXP_WE_LOW   = 5;  // ceil(45/10)
  localparam int EXP_OE_LOW   = 6;  // ceil(55/10)
  localparam int EXP_DONE     = 7;  // cycle after accept edge
  localparam int EXP_RDY_WR   = 7;
  localparam int EXP_RDY_RD   = 9;  // 6 read + 2 release + 1
  localparam int RELEASE_CYC  = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [12:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        req_ready, rsp_done;
  logic [7:0]  rsp_rdata;
  logic [12:0] mem_addr;
  logic        mem_ce_n, mem_ce2, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [7:0]  mem_dq_out;
  logic [7:0]  mem_dq_in;

  int checks = 0, bad = 0;
  bit finished = 0;

  always #(PERIOD/2) clk = ~clk;

  sram_seq_ctrl uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .rsp_rdata(rsp_rdata), .rsp_done(rsp_done), .mem_addr(mem_addr),
    .mem_ce_n(mem_ce_n), .mem_ce2(mem_ce2), .mem_we_n(mem_we_n),
    .mem_oe_n(mem_oe_n), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
    .mem_dq_in(mem_dq_in)
  );

  // ---------------- behavioural memory with slow bus release -------------
  logic [7:0] model_mem [int];
  logic [7:0] last_drv = '0;
  int         rel_cnt = 0;
  logic       mem_reading;
  logic       mem_driving;

  assign mem_reading = !mem_ce_n && mem_ce2 && !mem_oe_n && mem_we_n;
  assign mem_driving = mem_reading || (rel_cnt > 0);

  always @(*) begin
    if (mem_reading)
      mem_dq_in = model_mem.exists(int'(mem_addr)) ? model_mem[int'(mem_addr)] : 8'h00;
    else
      mem_dq_in = last_drv;
  end

  always @(posedge clk) begin
    if (mem_reading) begin
      rel_cnt  <= RELEASE_CYC;
      last_drv <= mem_dq_in;
    end else if (rel_cnt > 0) rel_cnt <= rel_cnt - 1;
  end

  always @(posedge mem_we_n) begin
    if (!mem_ce_n && mem_ce2) begin
      checks++;
      if (!mem_dq_oe) begin
        bad++;
        $display("FAIL R3: data drivers off at strobe end, got oe=%0b exp 1", mem_dq_oe);
      end
      model_mem[int'(mem_addr)] = mem_dq_out;
    end
  end

  always @(negedge clk) begin
    if (rst_n && mem_dq_oe) begin
      checks++;
      if (mem_driving || !mem_oe_n) begin
        bad++;
        $display("FAIL R6: bus conflict, got mem_driving=%0b oe_n=%0b exp 0/1",
                 mem_driving, mem_oe_n);
      end
    end
  end

  // ---------------- helpers ----------------------------------------------
  task automatic check(input bit ok, input string req, input int got, input int exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: got %0h exp %0h", req, got, exp);
    end
  endtask

  task automatic do_access(input bit wr, input logic [12:0] a, input logic [7:0] d,
                           output logic [7:0] rd, output int t_done, output int t_rdy,
                           output int n_we, output int n_oe, output bit addr_ok);
    int cyc;
    rd = '0; t_done = -1; t_rdy = -1; n_we = 0; n_oe = 0; addr_ok = 1;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    req_addr  = ~a;          // R9: later request fields must not leak in
    req_wdata = ~d;
    cyc = 1;
    while (cyc < 40) begin
      if (cyc == 1 && mem_addr != a) addr_ok = 0;
      if (!mem_we_n) begin
        n_we++;
        if (mem_addr != a) addr_ok = 0;
      end
      if (!mem_oe_n) n_oe++;
      if (rsp_done) begin
        t_done = cyc;
        rd = rsp_rdata;
      end
      if (req_ready) begin
        t_rdy = cyc;
        break;
      end
      @(negedge clk);
      cyc++;
    end
  endtask

  // ---------------- vector table -----------------------------------------
  typedef struct packed {
    logic        wr;
    logic [12:0] addr;
    logic [7:0]  data;   // write byte, or expected read byte
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 13'h0000, 8'hA5},
    '{1'b1, 13'h1FFF, 8'h3C},
    '{1'b1, 13'h0155, 8'h7E},
    '{1'b0, 13'h0000, 8'hA5},
    '{1'b0, 13'h1FFF, 8'h3C},
    '{1'b1, 13'h0000, 8'h5A},
    '{1'b0, 13'h0000, 8'h5A},
    '{1'b0, 13'h0155, 8'h7E},
    '{1'b1, 13'h0AAA, 8'hFF},
    '{1'b0, 13'h0AAA, 8'hFF}
  };

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      bad++;
      checks++;
      $display("FAIL watchdog: run did not complete, got timeout exp completion");
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd;
    int t_done, t_rdy, n_we, n_oe;
    bit addr_ok;

    // R1: reset state
    repeat (3) @(negedge clk);
    check(req_ready == 1'b1, "R1 ready", req_ready, 1);
    check(rsp_done  == 1'b0, "R1 done", rsp_done, 0);
    check(mem_ce_n  == 1'b1, "R1 ce_n", mem_ce_n, 1);
    check(mem_ce2   == 1'b0, "R1 ce2", mem_ce2, 0);
    check(mem_we_n  == 1'b1, "R1 we_n", mem_we_n, 1);
    check(mem_oe_n  == 1'b1, "R1 oe_n", mem_oe_n, 1);
    check(mem_dq_oe == 1'b0, "R1 dq_oe", mem_dq_oe, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready == 1'b1 && mem_ce_n == 1'b1 && mem_ce2 == 1'b0,
          "R1 after release", {req_ready, mem_ce_n, mem_ce2}, 3'b110);

    // table walk
    for (int i = 0; i < NV; i++) begin
      do_access(VECS[i].wr, VECS[i].addr, VECS[i].data, rd, t_done, t_rdy, n_we, n_oe, addr_ok);
      check(addr_ok, "R4 address", int'(addr_ok), 1);
      check(t_done == EXP_DONE, "R9 done cycle", t_done, EXP_DONE);
      if (VECS[i].wr) begin
        check(n_we == EXP_WE_LOW, "R5 strobe cycles", n_we, EXP_WE_LOW);
        check(n_oe == 0, "R3 oe_n high in write", n_oe, 0);
        check(t_rdy == EXP_RDY_WR, "R5 write ready", t_rdy, EXP_RDY_WR);
      end else begin
        check(n_oe == EXP_OE_LOW, "R7 oe cycles", n_oe, EXP_OE_LOW);
        check(n_we == 0, "R7 we_n high in read", n_we, 0);
        check(rd == VECS[i].data, "R7 read data", rd, VECS[i].data);
        check(t_rdy == EXP_RDY_RD, "R8 read ready", t_rdy, EXP_RDY_RD);
      end
      check(mem_ce_n == 1'b1 && mem_ce2 == 1'b0, "R2 idle deselect",
            {mem_ce_n, mem_ce2}, 2'b10);
    end

    // R9: one-cycle done pulse, checked right after a completion
    do_access(1'b1, 13'h0777, 8'h11, rd, t_done, t_rdy, n_we, n_oe, addr_ok);
    @(negedge clk);
    check(rsp_done == 1'b0, "R9 pulse width", rsp_done, 0);

    // R9 / R3: corrupted fields during the write above did not reach memory
    do_access(1'b0, 13'h0777, 8'h00, rd, t_done, t_rdy, n_we, n_oe, addr_ok);
    check(rd == 8'h11, "R9 fields ignored while busy", rd, 8'h11);
    do_access(1'b0, 13'h1888, 8'h00, rd, t_done, t_rdy, n_we, n_oe, addr_ok);
    check(rd == 8'h00, "R9 inverted address untouched", rd, 8'h00);

    // R8 / R6: read immediately followed by a write to another address
    do_access(1'b0, 13'h0155, 8'h00, rd, t_done, t_rdy, n_we, n_oe, addr_ok);
    check(t_rdy == EXP_RDY_RD, "R8 release before ready", t_rdy, EXP_RDY_RD);
    do_access(1'b1, 13'h0156, 8'hC3, rd, t_done, t_rdy, n_we, n_oe, addr_ok);
    do_access(1'b0, 13'h0156, 8'h00, rd, t_done, t_rdy, n_we, n_oe, addr_ok);
    check(rd == 8'hC3, "R3 write after read stored", rd, 8'hC3);

    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end
endmodule